// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one arbitrary single-lane SPI flash transaction at a time, up to a fixed number of serial clock cycles. Software uses a small byte-wide register bus. It fills a six-byte transmit bank, writes a length in clock cycles, and then sets a start bit in the command register. The engine lowers chip select and toggles SCLK in mode 0. It sends the transmit bank out, highest index first and most significant bit first, and drives zeros once the bank runs out. MISO is sampled on every rising edge into a ten-byte receive shift bank.

A read is performed by padding the transfer with zero bits and then reading the receive bank. Index 0 of that bank always holds the byte that arrived last. A per-instance parameter can add one cycle to transactions that software marks as reads, which covers sampling delay in the flash. The start bit reads back as busy and clears by itself when chip select is released.

Register map on the 6-bit bus address:

- 0x00 is the command register. Bit 2 starts the transaction on write and reads back as busy. Bit 3 marks a read.
- 0x01 is the length in SCLK cycles.
- 0x08 to 0x0D are transmit bytes 0 to 5.
- 0x10 to 0x19 are receive bytes 0 to 9.
- Any other address reads as zero.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, and the command, length and receive registers all read 0.
- R2: MOSI sends transmit byte 5 first and byte 0 last, most significant bit first within each byte. After 48 bits it sends 0 for every remaining cycle.
- R3: A transaction produces exactly as many SCLK rising edges as the length register holds. A read-marked transaction produces one more.
- R4: Reading the command register returns bit 2 set from the cycle after the start write until the transaction ends, and 0 afterwards.
- R5: Receive byte 0 (address 0x10) holds the 8 bits sampled last, with the first-sampled of those in bit 7. Byte k holds the 8 bits sampled before byte k-1.
- R6: The receive bank is one 80-bit shift register that keeps its contents across transactions. It is not cleared at start, and the oldest bits drop out.
- R7: Starting with an effective length of 0 finishes at once. Chip select never goes low, and busy reads 0 on the next cycle.
- R8: Writing the command register with bits 2 and 3 both set (value 0x0C) adds one SCLK cycle when the RD_EXTRA parameter is 1, which is the default.
- R9: A length write above 56 is stored as 56 and reads back as 56.
- R10: While busy, writes to the transmit bank, the length register and the command register are ignored. This includes a second start.
- R11: Chip select falls one system clock before the first rising SCLK edge. It rises 2*HALF_DIV system clocks after the last falling edge. SCLK is never high while chip select is high.
- R12: SCLK is high for HALF_DIV system clocks and low for HALF_DIV clocks between rising edges, with a default of 2 each. MOSI changes only while SCLK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from address |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
On every cycle, the assertions check the pin-level framing:
- SCLK stays low while chip select is high.
- The first rising edge follows chip select by one clock.
- MOSI holds steady while SCLK is high.
- Chip select is low only while the engine is busy.
- The number of rising edges in a frame never exceeds the maximum length plus one.

Only the bench's scenarios can show the content of a transfer: the transmit byte order and zero padding, the receive bank order and its carry-over between transactions, the read extension, length clamping, and the fact that writes made while busy are ignored.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int ADDR_W   = 6;
  localparam int CMD_ADDR = 0;
  localparam int CNT_ADDR = 1;
  localparam int TX_BASE  = 8;
  localparam int RX_BASE  = 16;
  localparam int GO_BIT   = 2;
  localparam int RDX_BIT  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } eng_state_e;
endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int RD_EXTRA = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  input  logic                  busy_i,
  input  logic [RX_BYTES*8-1:0] rx_flat_i,
  output logic [7:0]            bus_rdata,
  output logic [TX_BYTES*8-1:0] tx_flat_o,
  output logic                  start_o,
  output logic [$clog2(MAX_BITS+2)-1:0] len_o
);
  localparam int CNT_W = $clog2(MAX_BITS + 2);

  logic [7:0]          tx_q [TX_BYTES];
  logic [TX_BYTES-1:0] tx_we;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                cnt_we;

  // transmit bank: one enabled byte register per index
  for (genvar g = 0; g < TX_BYTES; g++) begin : g_tx
    assign tx_we[g] = bus_we && !busy_i && (bus_addr == ADDR_W'(TX_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q[g] <= '0;
      end else if (tx_we[g]) begin
        tx_q[g] <= bus_wdata;
      end
    end
    assign tx_flat_o[8*g +: 8] = tx_q[g];
  end

  // length register, clamped to the cycle limit
  always_comb begin
    cnt_we = bus_we && !busy_i && (bus_addr == ADDR_W'(CNT_ADDR));
    if (bus_wdata > 8'(MAX_BITS)) begin
      cnt_d = CNT_W'(MAX_BITS);
    end else begin
      cnt_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  // start request and effective length
  always_comb begin
    start_o = bus_we && !busy_i && (bus_addr == ADDR_W'(CMD_ADDR)) && bus_wdata[GO_BIT];
    if (bus_wdata[RDX_BIT] && (RD_EXTRA != 0)) begin
      len_o = cnt_q + CNT_W'(1);
    end else begin
      len_o = cnt_q;
    end
  end

  // read-back multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CMD_ADDR)) begin
      bus_rdata[GO_BIT] = busy_i;
    end
    if (bus_addr == ADDR_W'(CNT_ADDR)) begin
      bus_rdata = 8'(cnt_q);
    end
    for (int i = 0; i < TX_BYTES; i++) begin
      if (bus_addr == ADDR_W'(TX_BASE + i)) begin
        bus_rdata = tx_q[i];
      end
    end
    for (int i = 0; i < RX_BYTES; i++) begin
      if (bus_addr == ADDR_W'(RX_BASE + i)) begin
        bus_rdata = rx_flat_i[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
  import spi_cs_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int MAX_BITS = 56,
  parameter int HALF_DIV = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [$clog2(MAX_BITS+2)-1:0] len_i,
  input  logic [TX_BYTES*8-1:0]         tx_flat_i,
  output logic                          cs_n_o,
  output logic                          sclk_o,
  output logic                          mosi_o,
  output logic                          sample_o,
  output logic                          busy_o
);
  localparam int CNT_W   = $clog2(MAX_BITS + 2);
  localparam int DIV_W   = $clog2(2 * HALF_DIV) + 1;
  localparam int TX_BITS = TX_BYTES * 8;

  eng_state_e       state_q, state_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             sclk_q, sclk_d;
  logic             csn_q, csn_d;
  logic [TX_BITS-1:0] tx_shift;

  always_comb begin
    state_d  = state_q;
    div_d    = div_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    sclk_d   = sclk_q;
    csn_d    = csn_q;
    sample_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (len_i != '0)) begin
          state_d = ST_LEAD;
          csn_d   = 1'b0;
          cnt_d   = '0;
          len_d   = len_i;
        end
      end
      ST_LEAD: begin
        sclk_d   = 1'b1;
        sample_o = 1'b1;
        div_d    = DIV_W'(HALF_DIV - 1);
        state_d  = ST_HIGH;
      end
      ST_HIGH: begin
        if (div_q == '0) begin
          sclk_d = 1'b0;
          cnt_d  = cnt_q + CNT_W'(1);
          if ((cnt_q + CNT_W'(1)) == len_q) begin
            state_d = ST_TAIL;
            div_d   = DIV_W'(2 * HALF_DIV - 1);
          end else begin
            state_d = ST_LOW;
            div_d   = DIV_W'(HALF_DIV - 1);
          end
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      ST_LOW: begin
        if (div_q == '0) begin
          sclk_d   = 1'b1;
          sample_o = 1'b1;
          div_d    = DIV_W'(HALF_DIV - 1);
          state_d  = ST_HIGH;
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      ST_TAIL: begin
        if (div_q == '0) begin
          csn_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      sclk_q  <= sclk_d;
      csn_q   <= csn_d;
    end
  end

  // bit select by shifting: indices past the bank shift in zeros
  always_comb begin
    tx_shift = tx_flat_i << cnt_q;
    mosi_o   = 1'b0;
    if ((state_q == ST_LEAD) || (state_q == ST_HIGH) || (state_q == ST_LOW)) begin
      mosi_o = tx_shift[TX_BITS-1];
    end
  end

  assign cs_n_o = csn_q;
  assign sclk_o = sclk_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/spi_cs_rxbank.sv
module spi_cs_rxbank #(
  parameter int RX_BYTES = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic                  miso_i,
  output logic [RX_BYTES*8-1:0] rx_flat_o
);
  localparam int RX_BITS = RX_BYTES * 8;

  logic [RX_BITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[RX_BITS-2:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sample_i) begin
      sr_q <= sr_d;
    end
  end

  assign rx_flat_o = sr_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cs_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int HALF_DIV = 2,
  parameter int RD_EXTRA = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [5:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int CNT_W = $clog2(MAX_BITS + 2);

  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic [TX_BYTES*8-1:0] tx_flat;
  logic [RX_BYTES*8-1:0] rx_flat;
  logic                  start;
  logic [CNT_W-1:0]      len;
  logic                  eng_busy;
  logic                  sample;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  spi_cs_regs #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES),
    .MAX_BITS(MAX_BITS), .RD_EXTRA(RD_EXTRA)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy_i(eng_busy), .rx_flat_i(rx_flat), .bus_rdata(bus_rdata),
    .tx_flat_o(tx_flat), .start_o(start), .len_o(len)
  );

  spi_cs_engine #(
    .TX_BYTES(TX_BYTES), .MAX_BITS(MAX_BITS), .HALF_DIV(HALF_DIV)
  ) u_engine (
    .clk(clk), .rst_n(rst_n_int),
    .start_i(start), .len_i(len), .tx_flat_i(tx_flat),
    .cs_n_o(spi_cs_n), .sclk_o(spi_sclk), .mosi_o(spi_mosi),
    .sample_o(sample), .busy_o(eng_busy)
  );

  spi_cs_rxbank #(
    .RX_BYTES(RX_BYTES)
  ) u_rx (
    .clk(clk), .rst_n(rst_n_int),
    .sample_i(sample), .miso_i(spi_miso), .rx_flat_o(rx_flat)
  );
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk #(
  parameter int MAX_BITS = 56
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy
);
  logic       sclk_q;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        rise_cnt <= '0;
      end else if (sclk && !sclk_q) begin
        rise_cnt <= rise_cnt + 8'd1;
      end
    end
  end

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R11
  cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> $rose(sclk));

  // R12
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R4
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R3
  edge_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rise_cnt) <= MAX_BITS + 1);
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .mosi(spi_mosi), .busy(eng_busy)
);

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb;
  localparam int CLK_PERIOD = 8;  // 125 MHz
  localparam int HALF = 2;

  typedef struct packed {
    int          edges;
    logic [63:0] bits;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       bus_we;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       spi_cs_n;
  logic       spi_sclk;
  logic       spi_mosi;
  logic       spi_miso;

  int checks = 0;
  int errors = 0;
  int mon_checks = 0;
  int mon_errors = 0;
  int cs_falls = 0;
  int last_edges = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [63:0] slave_pat = '0;
  logic [79:0] rx_shadow = '0;

  spi_cmd_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // flash model: first bit at chip select, next bits on falling edges
  initial begin
    spi_miso = 1'b0;
    forever begin
      @(negedge spi_cs_n);
      begin
        int k;
        k = 0;
        spi_miso = slave_pat[63];
        while (1) begin
          @(negedge spi_sclk or posedge spi_cs_n);
          if (spi_cs_n) break;
          k++;
          spi_miso = (k < 64) ? slave_pat[63 - k] : 1'b0;
        end
      end
    end
  end

  // monitor: collects each frame and compares it with the scoreboard
  initial begin
    forever begin
      @(negedge spi_cs_n);
      begin
        time t_fall, t_first, t_last, t_rise;
        logic [63:0] cap;
        int n;
        exp_t e;
        t_fall = $time; t_first = 0; t_last = 0; cap = '0; n = 0;
        cs_falls++;
        while (1) begin
          @(posedge spi_sclk or posedge spi_cs_n);
          if (spi_cs_n) break;
          if (n == 0) t_first = $time;
          if (n < 64) cap[63 - n] = spi_mosi;
          n++;
          @(negedge spi_sclk);
          t_last = $time;
        end
        t_rise = $time;
        last_edges = n;
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_errors++;
          $display("FAIL R3 unexpected frame actual %0d edges expected none", n);
        end else begin
          e = exp_q.pop_front();
          if (n != e.edges) begin
            mon_errors++;
            $display("FAIL R3 edge count actual %0d expected %0d", n, e.edges);
          end
          mon_checks++;
          if (cap != e.bits) begin
            mon_errors++;
            $display("FAIL R2 mosi bits actual %h expected %h", cap, e.bits);
          end
        end
        mon_checks++;
        if ((t_first - t_fall) != CLK_PERIOD) begin
          mon_errors++;
          $display("FAIL R11 lead actual %0t expected %0d", t_first - t_fall, CLK_PERIOD);
        end
        mon_checks++;
        if ((t_rise - t_last) != 2 * HALF * CLK_PERIOD) begin
          mon_errors++;
          $display("FAIL R11 tail actual %0t expected %0d", t_rise - t_last, 2 * HALF * CLK_PERIOD);
        end
        mon_checks++;
        if (n > 0 && (t_last - t_first) != ((n - 1) * 2 * HALF + HALF) * CLK_PERIOD) begin
          mon_errors++;
          $display("FAIL R12 period actual %0t expected %0d", t_last - t_first,
                   ((n - 1) * 2 * HALF + HALF) * CLK_PERIOD);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 6'(a);
    bus_wdata = 8'(d);
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 6'(a);
    #2;
    d = bus_rdata;
  endtask

  // driver: loads, pushes the expected frame, starts and checks results
  task automatic run_xfer(input logic [47:0] tx, input int nbits, input bit rdx,
                          input logic [63:0] pat, input bit poke);
    exp_t e;
    int eff, falls0, guard, clamp;
    logic [7:0] v;
    for (int i = 0; i < 6; i++) wr(8 + i, int'(tx[8*i +: 8]));
    wr(1, nbits);
    clamp = (nbits > 56) ? 56 : nbits;
    eff = clamp + (rdx ? 1 : 0);
    slave_pat = pat;
    if (eff > 0) begin
      e.edges = eff;
      e.bits = {tx, 16'h0} & ~({64{1'b1}} >> eff);
      exp_q.push_back(e);
      for (int k = 0; k < eff; k++) rx_shadow = {rx_shadow[78:0], pat[63 - k]};
    end
    falls0 = cs_falls;
    wr(0, rdx ? 8'h0C : 8'h04);
    rd(0, v);
    if (eff == 0) begin
      chk(v == 8'h00, "R7 busy after zero length", v, 0);
      repeat (6) @(negedge clk);
      chk(cs_falls == falls0, "R7 chip select stayed high", cs_falls, falls0);
    end else begin
      chk(v == 8'h04, "R4 busy set", v, 4);
      if (poke) begin
        wr(13, int'(~tx[47:40]));
        wr(1, 3);
        wr(0, 4);
      end
      guard = 0;
      do begin
        rd(0, v);
        guard++;
      end while (v[2] && guard < 2000);
      chk(v == 8'h00, "R4 busy cleared", v, 0);
      repeat (2) @(negedge clk);
      chk(cs_falls == falls0 + 1, "R10 one frame per start", cs_falls, falls0 + 1);
      if (rdx) chk(last_edges == eff, "R8 read extension edges", last_edges, eff);
      if (poke) begin
        rd(13, v);
        chk(v == tx[47:40], "R10 tx byte kept", v, tx[47:40]);
        rd(1, v);
        chk(int'(v) == clamp, "R10 length kept", v, clamp);
      end
      for (int i = 0; i < 10; i++) begin
        rd(16 + i, v);
        chk(v == rx_shadow[8*i +: 8], "R5 R6 receive byte", v, rx_shadow[8*i +: 8]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0;
    bus_we = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    chk(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
    rd(0, v); chk(v == 0, "R1 command", v, 0);
    rd(1, v); chk(v == 0, "R1 length", v, 0);
    rd(16, v); chk(v == 0, "R1 receive", v, 0);

    // R2 R3 R5 full-length transfer, zero padding after 48 bits
    run_xfer(48'hA1B2C3D4E5F6, 56, 1'b0, 64'h0123456789ABCDEF, 1'b0);
    // R6 a second transfer keeps shifting into the same bank
    run_xfer(48'h5A3C00000000, 16, 1'b0, 64'hF00D_0000_0000_0000, 1'b0);
    // R8 read-marked transfer gets one extra cycle
    run_xfer(48'h9F0000000000, 8, 1'b1, 64'hC3E1_0000_0000_0000, 1'b0);
    // R7 zero length
    run_xfer(48'h111111111111, 0, 1'b0, 64'h0, 1'b0);
    // R9 length clamp
    wr(1, 63);
    rd(1, v); chk(v == 8'd56, "R9 clamp readback", v, 56);
    run_xfer(48'h0F1E2D3C4B5A, 63, 1'b0, 64'hAAAA5555CCCC3333, 1'b0);
    // R10 writes while busy are ignored
    run_xfer(48'h8001FE7F4224, 56, 1'b0, 64'h1248_8421_F0F0_0F0F, 1'b1);
    // odd length
    run_xfer(48'hB7E100000000, 12, 1'b0, 64'h6DB0_0000_0000_0000, 1'b0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule